// File: doc/BRIEF.md
# Multiplying Delay-Locked Clock Generator: Digital Loop Controller

This block is the digital control core of a multiplying delay-locked clock generator. A phase detector outside the block compares the output clock against the reference once per comparison window. It compares the (N+1)th rising output edge with the (M+1)th rising reference edge, both counted from the start of the window. The result reaches this block as a one-bit decision, where "early" means the oscillator is too fast. The block integrates these decisions in a saturating loop-filter register. The upper field of the register drives a coarse delay line through a thermometer code. The lower field drives a fine delay line as a plain binary code.

The same window strobe also advances the select code of the 3-way multiplexer in front of the oscillator. While unlocked, the select code rotates through ring-oscillator, supply-injection and reference-injection modes. Once lock is declared, the supply-injection step is dropped, and the oscillator alternates between free running and reference injection. Lock is declared when the decisions have dithered up and down for a run of consecutive windows, which shows that the loop is sitting on the phase-aligned point. Clearing the enable input returns the sequencer to a known state and removes lock. It leaves the delay code in place, so a later restart resumes from the last delay value.

Top module: `mdll_loop_ctrl`

## Requirements
- R1: While reset is high, the register clears at the next rising edge, so the coarse code, the fine code and the mode select all read zero (mode 00 = ring oscillator) and locked is low.
- R2: On a clock edge with enable high and the window strobe high, the register rises by exactly 1 when the decision input is 1 (early). It falls by exactly 1 when the decision input is 0 (late).
- R3: The register saturates: an early decision at 1023 leaves it at 1023, and a late decision at 0 leaves it at 0. It never wraps.
- R4: The coarse output is a 16-bit thermometer code. Its bits 0 up to k-1 are set and all others are clear, where k is the value of register bits [9:6], so k = 0 gives all zeros. The fine output equals register bits [5:0].
- R5: On a clock edge with the window strobe low, the register, the mode select and the lock state do not change.
- R6: When locked is low before a strobe edge, each strobe edge moves the mode select in a cycle from 00 (ring oscillator) to 01 (supply injection), then to 10 (reference injection), and back to 00.
- R7: When locked is high before a strobe edge, the edge moves mode 00 to 10, mode 10 to 00, and mode 01 to 10. As a result, 01 never appears twice running while lock holds.
- R8: A strobe window alternates when its decision differs from the decision of the previous strobe window since the last reset or enable drop. The first window after that point never alternates. Locked rises on the edge of the 8th consecutive alternating window. A non-alternating window restarts the run, and locked, once high, stays high until reset or enable goes low.
- R9: On a clock edge with enable low, locked and the alternation run clear, the mode select returns to 00, and the register holds its value. The window strobe and decision inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Loop enable; low freezes the delay code and clears lock |
| win_strobe | input | 1 | One-cycle pulse marking the end of a comparison window |
| early_late | input | 1 | Phase decision for the window: 1 early, 0 late |
| coarse_therm | output | 16 | Thermometer code for the coarse delay line |
| fine_code | output | 6 | Binary code for the fine delay line |
| mode_sel | output | 2 | Oscillator input select: 00 ring, 01 supply injection, 10 reference injection |
| locked | output | 1 | Lock indication |

## Verification
The bench builds the controller with its default parameters: a 10-bit register split 4/6 and a lock run of 8. With these values the register can be driven from zero to its upper limit with about a thousand early windows, so both saturation points and every one of the 16 coarse codes come within reach of one short run. The lock run of 8 is short enough that the bench can check a failed run of seven alternations followed by a real lock. It can also check the locked two-mode rotation from each possible starting mode, and the loss of lock when enable is dropped, all within a few thousand cycles.

// File: rtl/mdll_ctrl_pkg.sv
package mdll_ctrl_pkg;

    // Oscillator input select encoding
    typedef enum logic [1:0] {
        MODE_RING   = 2'b00,
        MODE_SUPPLY = 2'b01,
        MODE_REFINJ = 2'b10
    } osc_mode_e;

    // One window decision as seen by the loop logic
    typedef struct packed {
        logic valid;   // enabled window boundary
        logic early;   // 1: oscillator early, lengthen delay
    } win_dec_t;

    // Mode rotation: three modes while unlocked, two once locked
    function automatic osc_mode_e next_mode(osc_mode_e cur, logic is_locked);
        case (cur)
            MODE_RING:   return is_locked ? MODE_REFINJ : MODE_SUPPLY;
            MODE_SUPPLY: return MODE_REFINJ;
            default:     return MODE_RING;
        endcase
    endfunction

endpackage

// File: rtl/mdll_loop_accum.sv
module mdll_loop_accum
    import mdll_ctrl_pkg::*;
#(
    parameter int unsigned ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  win_dec_t         step,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] ACC_TOP = '1;
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (step.valid) begin
            if (step.early) begin
                if (acc != ACC_TOP) acc <= acc + ACC_ONE;
            end else begin
                if (acc != '0) acc <= acc - ACC_ONE;
            end
        end
    end
endmodule

// File: rtl/mdll_delay_decode.sv
module mdll_delay_decode #(
    parameter int unsigned ACC_W    = 10,
    parameter int unsigned COARSE_W = 4
) (
    input  logic [ACC_W-1:0]          acc,
    output logic [(2**COARSE_W)-1:0]  therm,
    output logic [ACC_W-COARSE_W-1:0] fine
);
    localparam int unsigned THERM_W = 2 ** COARSE_W;
    localparam int unsigned FINE_W  = ACC_W - COARSE_W;

    logic [COARSE_W-1:0] coarse;
    assign coarse = acc[ACC_W-1 -: COARSE_W];
    assign fine   = acc[FINE_W-1:0];

    for (genvar gi = 0; gi < THERM_W; gi++) begin : g_therm
        assign therm[gi] = (coarse > COARSE_W'(gi));
    end
endmodule

// File: rtl/mdll_lock_detect.sv
module mdll_lock_detect
    import mdll_ctrl_pkg::*;
#(
    parameter int unsigned LOCK_RUN = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  win_dec_t step,
    output logic     locked
);
    localparam int unsigned     RUN_W   = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);
    localparam logic [RUN_W-1:0] RUN_ONE = {{(RUN_W-1){1'b0}}, 1'b1};

    logic             have_prev;
    logic             prev_early;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             alt;

    always_comb begin
        alt = have_prev && (step.early != prev_early);
        if (!alt)                run_nx = '0;
        else if (run_q == RUN_TOP) run_nx = run_q;
        else                     run_nx = run_q + RUN_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            have_prev  <= 1'b0;
            prev_early <= 1'b0;
            run_q      <= '0;
            locked     <= 1'b0;
        end else if (step.valid) begin
            have_prev  <= 1'b1;
            prev_early <= step.early;
            run_q      <= run_nx;
            if (run_nx == RUN_TOP) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/mdll_mode_seq.sv
module mdll_mode_seq
    import mdll_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      advance,
    input  logic      is_locked,
    output osc_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst || !enable) mode <= MODE_RING;
        else if (advance)   mode <= next_mode(mode, is_locked);
    end
endmodule

// File: rtl/mdll_loop_ctrl.sv
module mdll_loop_ctrl
    import mdll_ctrl_pkg::*;
#(
    parameter int unsigned ACC_W    = 10,
    parameter int unsigned COARSE_W = 4,
    parameter int unsigned LOCK_RUN = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable,
    input  logic                        win_strobe,
    input  logic                        early_late,
    output logic [(2**COARSE_W)-1:0]    coarse_therm,
    output logic [ACC_W-COARSE_W-1:0]   fine_code,
    output logic [1:0]                  mode_sel,
    output logic                        locked
);
    win_dec_t         step;
    logic [ACC_W-1:0] acc_q;
    osc_mode_e        mode_q;
    logic             lock_q;

    assign step.valid = enable && win_strobe;
    assign step.early = early_late;

    mdll_loop_accum #(.ACC_W(ACC_W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .acc  (acc_q)
    );

    mdll_delay_decode #(.ACC_W(ACC_W), .COARSE_W(COARSE_W)) u_decode (
        .acc   (acc_q),
        .therm (coarse_therm),
        .fine  (fine_code)
    );

    mdll_lock_detect #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .step   (step),
        .locked (lock_q)
    );

    mdll_mode_seq u_mode (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .advance   (step.valid),
        .is_locked (lock_q),
        .mode      (mode_q)
    );

    assign mode_sel = mode_q;
    assign locked   = lock_q;
endmodule

// File: rtl/mdll_loop_ctrl_chk.sv
module mdll_loop_ctrl_chk #(
    parameter int unsigned ACC_W    = 10,
    parameter int unsigned COARSE_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      enable,
    input logic                      win_strobe,
    input logic                      early_late,
    input logic [ACC_W-1:0]          acc,
    input logic [(2**COARSE_W)-1:0]  therm,
    input logic [ACC_W-COARSE_W-1:0] fine,
    input logic [1:0]                mode,
    input logic                      locked
);
    localparam int unsigned      FINE_W  = ACC_W - COARSE_W;
    localparam logic [ACC_W-1:0] ACC_TOP = '1;
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rst || (acc == '0 && mode == 2'b00 && !locked)));

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && early_late && acc != ACC_TOP) |=> (acc == $past(acc) + ACC_ONE));

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && !early_late && acc != '0) |=> (acc == $past(acc) - ACC_ONE));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && early_late && acc == ACC_TOP) |=> (acc == ACC_TOP));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && !early_late && acc == '0) |=> (acc == '0));

    p_therm_shape_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(therm) == int'(acc[ACC_W-1 -: COARSE_W])) && (((therm + 1'b1) & therm) == '0)
        && (fine == acc[FINE_W-1:0]));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && !win_strobe) |=> ($stable(acc) && $stable(mode) && $stable(locked)));

    p_supply_follows_ring_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && !locked && mode == 2'b00) |=> (mode == 2'b01));

    p_locked_to_refinj_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && win_strobe && locked && mode != 2'b10) |=> (mode == 2'b10));

    p_lock_on_window_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(enable && win_strobe));

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (!enable) |=> (!locked && mode == 2'b00 && acc == $past(acc)));

    p_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind mdll_loop_ctrl mdll_loop_ctrl_chk #(.ACC_W(ACC_W), .COARSE_W(COARSE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .win_strobe (win_strobe),
    .early_late (early_late),
    .acc        (acc_q),
    .therm      (coarse_therm),
    .fine       (fine_code),
    .mode       (mode_sel),
    .locked     (locked)
);

// File: tb/test_mdll_loop_ctrl.sv
module test_mdll_loop_ctrl;
    localparam int ACC_MAX  = 1023;
    localparam int LOCK_RUN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        win_strobe = 1'b0;
    logic        early_late = 1'b0;
    logic [15:0] coarse_therm;
    logic [5:0]  fine_code;
    logic [1:0]  mode_sel;
    logic        locked;

    always #4 clk = ~clk;

    mdll_loop_ctrl i_mdll_loop_ctrl (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .win_strobe   (win_strobe),
        .early_late   (early_late),
        .coarse_therm (coarse_therm),
        .fine_code    (fine_code),
        .mode_sel     (mode_sel),
        .locked       (locked)
    );

    typedef struct {
        logic [15:0] therm;
        logic [5:0]  fine;
        logic [1:0]  mode;
        logic        lock;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    // Reference model state
    int m_acc = 0, m_mode = 0, m_run = 0;
    bit m_lock = 0, m_have = 0, m_prev = 0;

    task automatic drive(input bit r, input bit en, input bit stb, input bit dec, input string tag);
        exp_t e;
        bit   alt;
        @(negedge clk);
        rst = r; enable = en; win_strobe = stb; early_late = dec;
        if (r) begin
            m_acc = 0; m_mode = 0; m_lock = 0; m_run = 0; m_have = 0; m_prev = 0;
        end else if (!en) begin
            m_lock = 0; m_run = 0; m_have = 0; m_mode = 0;
        end else if (stb) begin
            // mode uses the lock state held before this edge
            if (m_mode == 0)      m_mode = m_lock ? 2 : 1;
            else if (m_mode == 1) m_mode = 2;
            else                  m_mode = 0;
            if (dec && m_acc < ACC_MAX) m_acc++;
            if (!dec && m_acc > 0)      m_acc--;
            alt = m_have && (dec != m_prev);
            m_run = alt ? ((m_run < LOCK_RUN) ? m_run + 1 : m_run) : 0;
            if (m_run == LOCK_RUN) m_lock = 1;
            m_prev = dec; m_have = 1;
        end
        e.therm = 16'((32'h1 << (m_acc >> 6)) - 1);
        e.fine  = 6'(m_acc & 63);
        e.mode  = 2'(m_mode);
        e.lock  = m_lock;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares one expected item per clock, between edges
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                bit   bad;
                e = exp_q.pop_front();
                bad = 0;
                n_vec++;
                if (coarse_therm !== e.therm) begin
                    $display("FAIL %s/R4 coarse_therm actual %h expected %h", e.tag, coarse_therm, e.therm);
                    bad = 1;
                end
                if (fine_code !== e.fine) begin
                    $display("FAIL %s/R4 fine_code actual %0d expected %0d", e.tag, fine_code, e.fine);
                    bad = 1;
                end
                if (mode_sel !== e.mode) begin
                    $display("FAIL %s mode_sel actual %b expected %b", e.tag, mode_sel, e.mode);
                    bad = 1;
                end
                if (locked !== e.lock) begin
                    $display("FAIL %s locked actual %b expected %b", e.tag, locked, e.lock);
                    bad = 1;
                end
                if (bad) n_bad++;
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        // R1: reset state
        drive(1, 0, 0, 0, "R1");
        drive(1, 0, 0, 0, "R1");
        drive(0, 1, 0, 0, "R1");
        // R5: idle windows change nothing
        for (int i = 0; i < 4; i++) drive(0, 1, 0, 1, "R5");
        // R3: lates at zero stay at zero; R6 mode rotation
        for (int i = 0; i < 3; i++) drive(0, 1, 1, 0, "R3_R6");
        // R2: early steps with idle cycles between
        for (int i = 0; i < 6; i++) begin
            drive(0, 1, 1, 1, "R2_R6");
            drive(0, 1, 0, 0, "R5");
        end
        drive(0, 1, 1, 0, "R2");
        // R4/R3: ramp to the top and past it
        for (int i = 0; i < ACC_MAX + 6; i++) drive(0, 1, 1, 1, "R3_R4");
        // R4: walk down across several coarse boundaries
        for (int i = 0; i < 200; i++) drive(0, 1, 1, 0, "R2_R4");
        // R8: seven alternations do not lock, a broken run restarts
        for (int i = 0; i < 8; i++) drive(0, 1, 1, i[0], "R8");
        drive(0, 1, 1, 1, "R8");
        // R8: full run of alternations locks; R7 two-mode rotation
        for (int i = 0; i < 14; i++) drive(0, 1, 1, i[0], "R7_R8");
        // lock stays after a non-alternating window
        drive(0, 1, 1, 1, "R8");
        drive(0, 1, 1, 1, "R7_R8");
        drive(0, 1, 0, 0, "R5");
        // R9: enable low clears lock and mode, ignores strobes
        for (int i = 0; i < 5; i++) drive(0, 0, 1, i[0], "R9");
        drive(0, 1, 0, 0, "R9");
        // relock from each starting mode offset
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < k + 1; i++) drive(0, 1, 1, 1, "R6");
            for (int i = 0; i < 12; i++) drive(0, 1, 1, ~i[0], "R7_R8");
            drive(0, 0, 0, 0, "R9");
        end
        // pseudo-random decisions with gaps
        lf = 8'hA5;
        for (int i = 0; i < 600; i++) begin
            drive(0, (i % 97) != 50, (i % 3) != 2, lf[0], "R2_R7_R8");
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        // R1: reset mid-run
        drive(1, 1, 1, 1, "R1");
        drive(0, 1, 0, 0, "R1");
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule